// File: doc/BRIEF.md
# Pull resistor programming sequencer

This block holds the latched pull-resistor setting of every pad in a bank of general-purpose pins and drives one pull-up enable and one pull-down enable per pin. Software cannot write the pull state of a pin directly. It writes a 2-bit pull code into a control register, lets that code settle, raises the pin's bit in a clock-mask register, leaves it raised, and then writes the mask back to zero. A pin takes the code only if both waiting periods lasted long enough. A write that comes too early is ignored.

The pull state cannot be read back. The control register and the clock-mask words can be read. An automatic mode runs the whole write, wait, pulse and wait sequence from a single command write. It reports a busy flag while the sequence runs and refuses other register writes until the sequence is done. The pin count and the minimum wait length are parameters. The clock-mask bits for pin p sit in word p/32, bit p mod 32. The words start at offset 0x98 and follow each other every 4 bytes.

Top module: `pull_sequencer`

## Requirements
- R1: After reset all pull-up and pull-down enables are 0, the control register, both clock-mask words and the busy flag read 0, and the busy port is 0.
- R2: Control code 0 selects no pull, 1 selects pull-down (pull_dn_en=1) and 2 selects pull-up (pull_up_en=1). The sequence sets the pin's clock-mask bit (word p/32 at 0x98+4*(p/32), bit p mod 32) and later clears it. The pin's outputs take the new code on the edge of the clearing write, and only the pins whose bit was set change.
- R3: The rising write of a clock-mask bit arms a pin only if at least SETUP_CYCLES clock edges have passed since the last write to the control register (offset 0x94). If it comes sooner, the pin keeps its previous pull state.
- R4: The clearing write of a clock-mask bit captures the code only if at least SETUP_CYCLES clock edges have passed since the last write to that clock-mask word. If it comes sooner, the pin keeps its previous pull state.
- R5: Control code 3 is reserved. A sequence that uses it changes no pull output.
- R6: Several pins in both clock-mask words can be programmed by one sequence, and pins whose bits stay 0 keep their state.
- R7: Reads return data on the clock edge that follows the read strobe. The control register reads back in bits [1:0]. A clock-mask word reads back its written value with bits beyond the last pin as 0. Unmapped offsets read 0, and no register returns the pull state.
- R8: A write to the command register at 0xA0 (code in bits [1:0], pin number in bits [15:8]) runs the full sequence for that pin with the minimum waits. Busy (the port and bit 31 at 0xA0) is high for exactly 2*SETUP_CYCLES cycles, and the result matches the manual sequence.
- R9: While busy, bus writes to the control, clock-mask and command registers are ignored.
- R10: A command with code 3 or a pin number of NUM_PINS or more is ignored and does not start the sequence.
- R11: A rewrite of a clock-mask word that keeps a bit high restarts that word's hold timing, so the clearing write must again wait SETUP_CYCLES edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pull_up_en | output | NUM_PINS | Per-pin pull-up enable |
| pull_dn_en | output | NUM_PINS | Per-pin pull-down enable |
| auto_busy | output | 1 | Automatic sequence in progress |

## Verification
On every cycle the assertions check the following. A pin's pull outputs change only right after a clearing write to that pin's mask bit. A pin is armed only when the setup timer had expired and the code was valid. A fresh control value always restarts the setup timer. Busy bus writes never alter the control register, and busy ends only with a sequencer write to a clock-mask word. Only the bench scenarios can show the rest: the exact setup and hold boundaries, the per-pin mapping across both words, the length of the busy window, and the readback values.

// File: rtl/pullseq_pkg.sv
package pullseq_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h94;
  localparam logic [7:0] OFF_CLK0 = 8'h98;
  localparam logic [7:0] OFF_CMD  = 8'hA0;

  localparam logic [1:0] PULL_NONE = 2'd0;
  localparam logic [1:0] PULL_DOWN = 2'd1;
  localparam logic [1:0] PULL_UP   = 2'd2;
  localparam logic [1:0] PULL_RSVD = 2'd3;

  typedef enum logic [1:0] {
    AUTO_IDLE  = 2'd0,
    AUTO_SETUP = 2'd1,
    AUTO_HOLD  = 2'd2
  } auto_state_e;
endpackage

// File: rtl/pullseq_age.sv
// Saturating counter of clock edges since the last restart.
module pullseq_age #(
  parameter int LIMIT = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic ok
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= TOP;
    else if (restart)  cnt <= W'(1);
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign ok = (cnt == TOP);
endmodule

// File: rtl/pullseq_pins.sv
// Per-pin arm and capture logic with registered pull enables.
module pullseq_pins
  import pullseq_pkg::*;
#(
  parameter int NUM_PINS = 54
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] word_wr,
  input  logic [NUM_PINS-1:0] new_bits,
  input  logic [NUM_PINS-1:0] old_bits,
  input  logic [NUM_PINS-1:0] hold_ok,
  input  logic [1:0]          ctrl,
  input  logic                setup_ok,
  output logic [NUM_PINS-1:0] pu,
  output logic [NUM_PINS-1:0] pd
);
  logic [NUM_PINS-1:0]       armed;
  logic [NUM_PINS-1:0][1:0]  code;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= '0;
      code  <= '0;
      pu    <= '0;
      pd    <= '0;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (word_wr[i]) begin
          if (new_bits[i] && !old_bits[i]) begin
            armed[i] <= setup_ok && (ctrl != PULL_RSVD);
            code[i]  <= ctrl;
          end else if (!new_bits[i] && old_bits[i]) begin
            armed[i] <= 1'b0;
            if (armed[i] && hold_ok[i]) begin
              pu[i] <= (code[i] == PULL_UP);
              pd[i] <= (code[i] == PULL_DOWN);
            end
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    // R2
    pull_change_chk: assert property (@(posedge clk) disable iff (rst)
      (pu[g] != $past(pu[g]) || pd[g] != $past(pd[g]))
        |-> $past(word_wr[g] && old_bits[g] && !new_bits[g]));
    // R3
    arm_setup_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(armed[g]) |-> $past(setup_ok));
    // R5
    arm_code_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(armed[g]) |-> ($past(ctrl) != PULL_RSVD));
  end
endmodule

// File: rtl/pullseq_auto.sv
// Automatic sequencer: control write, setup wait, mask set, hold wait, mask clear.
module pullseq_auto
  import pullseq_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int WORDS    = 2,
  parameter int WIDX_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [1:0]        cmd_code,
  input  logic [7:0]        cmd_pin,
  input  logic              setup_ok,
  input  logic [WORDS-1:0]  hold_ok,
  output logic              busy,
  output logic              ctrl_we,
  output logic [1:0]        ctrl_val,
  output logic              clk_we,
  output logic [WIDX_W-1:0] clk_idx,
  output logic [31:0]       clk_data
);
  auto_state_e state;
  logic [7:0]  pin_q;
  logic        cmd_ok;
  logic        accept;

  assign cmd_ok   = (cmd_code != PULL_RSVD) && (int'(cmd_pin) < NUM_PINS);
  assign accept   = cmd_wr && (state == AUTO_IDLE) && cmd_ok;
  assign ctrl_we  = accept;
  assign ctrl_val = cmd_code;
  assign clk_idx  = WIDX_W'(pin_q >> 5);
  assign clk_we   = ((state == AUTO_SETUP) && setup_ok) ||
                    ((state == AUTO_HOLD) && hold_ok[clk_idx]);
  assign clk_data = (state == AUTO_SETUP) ? (32'd1 << pin_q[4:0]) : 32'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= AUTO_IDLE;
      pin_q <= '0;
      busy  <= 1'b0;
    end else begin
      case (state)
        AUTO_IDLE: if (accept) begin
          state <= AUTO_SETUP;
          pin_q <= cmd_pin;
          busy  <= 1'b1;
        end
        AUTO_SETUP: if (clk_we) state <= AUTO_HOLD;
        AUTO_HOLD: if (clk_we) begin
          state <= AUTO_IDLE;
          busy  <= 1'b0;
        end
        default: begin
          state <= AUTO_IDLE;
          busy  <= 1'b0;
        end
      endcase
    end
  end

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(clk_we));
  // R10
  bad_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !busy && cmd_code == PULL_RSVD) |=> !busy);
endmodule

// File: rtl/pull_sequencer.sv
module pull_sequencer
  import pullseq_pkg::*;
#(
  parameter int NUM_PINS     = 54,
  parameter int SETUP_CYCLES = 150
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_PINS-1:0] pull_up_en,
  output logic [NUM_PINS-1:0] pull_dn_en,
  output logic                auto_busy
);
  localparam int WORDS  = (NUM_PINS + 31) / 32;
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  function automatic logic [31:0] word_mask(int w);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < 32; b++)
      if (w * 32 + b < NUM_PINS) m[b] = 1'b1;
    return m;
  endfunction

  logic [1:0]              ctrl_q;
  logic [WORDS-1:0][31:0]  clk_q;
  logic [WORDS-1:0][31:0]  word_next;
  logic [WORDS-1:0]        word_we;
  logic [WORDS-1:0]        hold_ok;
  logic                    setup_ok;
  logic                    bus_ok;
  logic                    ctrl_we;
  logic [31:0]             rd_mux;

  logic                    a_ctrl_we;
  logic [1:0]              a_ctrl_val;
  logic                    a_clk_we;
  logic [WIDX_W-1:0]       a_clk_idx;
  logic [31:0]             a_clk_data;

  logic [NUM_PINS-1:0]     pin_we, pin_new, pin_old, pin_hold;

  assign bus_ok  = bus_wr && !auto_busy;
  assign ctrl_we = a_ctrl_we || (bus_ok && bus_addr == OFF_CTRL);

  pullseq_auto #(.NUM_PINS(NUM_PINS), .WORDS(WORDS), .WIDX_W(WIDX_W)) u_auto (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (bus_wr && bus_addr == OFF_CMD),
    .cmd_code (bus_wdata[1:0]),
    .cmd_pin  (bus_wdata[15:8]),
    .setup_ok (setup_ok),
    .hold_ok  (hold_ok),
    .busy     (auto_busy),
    .ctrl_we  (a_ctrl_we),
    .ctrl_val (a_ctrl_val),
    .clk_we   (a_clk_we),
    .clk_idx  (a_clk_idx),
    .clk_data (a_clk_data)
  );

  pullseq_age #(.LIMIT(SETUP_CYCLES)) u_setup_age (
    .clk     (clk),
    .rst     (rst),
    .restart (ctrl_we),
    .ok      (setup_ok)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [7:0]  ADDR = OFF_CLK0 + 8'(4 * w);
    localparam logic [31:0] MASK = word_mask(w);

    assign word_we[w]   = (a_clk_we && a_clk_idx == WIDX_W'(w)) ||
                          (bus_ok && bus_addr == ADDR);
    assign word_next[w] = (a_clk_we ? a_clk_data : bus_wdata) & MASK;

    pullseq_age #(.LIMIT(SETUP_CYCLES)) u_hold_age (
      .clk     (clk),
      .rst     (rst),
      .restart (word_we[w]),
      .ok      (hold_ok[w])
    );
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_we[p]   = word_we[p / 32];
    assign pin_new[p]  = word_next[p / 32][p % 32];
    assign pin_old[p]  = clk_q[p / 32][p % 32];
    assign pin_hold[p] = hold_ok[p / 32];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= PULL_NONE;
      clk_q  <= '0;
    end else begin
      if (a_ctrl_we)    ctrl_q <= a_ctrl_val;
      else if (ctrl_we) ctrl_q <= bus_wdata[1:0];
      for (int w = 0; w < WORDS; w++)
        if (word_we[w]) clk_q[w] <= word_next[w];
    end
  end

  pullseq_pins #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .word_wr  (pin_we),
    .new_bits (pin_new),
    .old_bits (pin_old),
    .hold_ok  (pin_hold),
    .ctrl     (ctrl_q),
    .setup_ok (setup_ok),
    .pu       (pull_up_en),
    .pd       (pull_dn_en)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFF_CTRL) rd_mux = {30'd0, ctrl_q};
    if (bus_addr == OFF_CMD)  rd_mux = {auto_busy, 31'd0};
    for (int w = 0; w < WORDS; w++)
      if (bus_addr == OFF_CLK0 + 8'(4 * w)) rd_mux = clk_q[w];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R9
  busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (auto_busy && bus_wr) |=> $stable(ctrl_q));
  // R3
  ctrl_age_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q != $past(ctrl_q)) |-> !setup_ok);
  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

// File: tb/pull_sequencer_bench.sv
module pull_sequencer_bench;
  localparam int NP = 54;
  localparam int S  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pull_up_en, pull_dn_en;
  logic        auto_busy;

  logic [NP-1:0] exp_pu = '0;
  logic [NP-1:0] exp_pd = '0;
  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  pull_sequencer #(.NUM_PINS(NP), .SETUP_CYCLES(S)) u_pull_sequencer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en), .auto_busy(auto_busy)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_pulls(input string tag);
    chk(tag, {pull_up_en, pull_dn_en}, {exp_pu, exp_pd});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] waddr(input int p);
    return 8'h98 + 8'(4 * (p / 32));
  endfunction

  function automatic void apply(input int p, input logic [1:0] v);
    exp_pu[p] = (v == 2'd2);
    exp_pd[p] = (v == 2'd1);
  endfunction

  // manual sequence: setup gap = ns+1 edges, hold gap = nh+1 edges
  task automatic prog(input int p, input logic [1:0] v, input int ns, input int nh);
    wr(8'h94, {30'd0, v});
    idle(ns);
    wr(waddr(p), 32'd1 << (p % 32));
    idle(nh);
    wr(waddr(p), 32'd0);
    if (ns + 1 >= S && nh + 1 >= S && v != 2'd3) apply(p, v);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (auto_busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] d;
    int n;
    logic [31:0] m0, m1;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk_pulls("R1 pulls after reset");
    chk("R1 busy port", auto_busy, 0);
    rd(8'h94, d); chk("R1 ctrl", d, 0);
    rd(8'h98, d); chk("R1 clk word0", d, 0);
    rd(8'h9C, d); chk("R1 clk word1", d, 0);
    rd(8'hA0, d); chk("R1 busy bit", d, 0);

    // R2 / R5 sweep: every pin, every code, minimum legal waits
    for (int v = 0; v < 4; v++)
      for (int p = 0; p < NP; p++) begin
        prog(p, 2'(v), S - 1, S - 1);
        chk_pulls(v == 3 ? "R5 reserved code" : "R2 pin sweep");
      end

    // R3 setup boundary sweep on pin 5
    for (int ns = 0; ns <= S + 1; ns++) begin
      prog(5, (ns % 2) ? 2'd1 : 2'd0, ns, S - 1);
      chk_pulls("R3 setup sweep");
    end

    // R4 hold boundary sweep on pin 40
    for (int nh = 0; nh <= S + 1; nh++) begin
      prog(40, (nh % 2) ? 2'd2 : 2'd1, S - 1, nh);
      chk_pulls("R4 hold sweep");
    end

    // R11 rewrite restarts hold timing
    wr(8'h94, 32'd1);
    idle(S);
    wr(8'h9C, 32'd1 << 1);
    idle(S - 2);
    wr(8'h9C, 32'd1 << 1);
    idle(S - 2);
    wr(8'h9C, 32'd0);
    chk_pulls("R11 short hold after rewrite");
    wr(8'h94, 32'd1);
    idle(S);
    wr(8'h9C, 32'd1 << 1);
    idle(S - 2);
    wr(8'h9C, 32'd1 << 1);
    idle(S - 1);
    wr(8'h9C, 32'd0);
    apply(33, 2'd1);
    chk_pulls("R11 full hold after rewrite");

    // R6 several pins in both words
    m0 = 32'hA5A5_0F0F;
    m1 = 32'h002A_5555;
    wr(8'h94, 32'd1);
    idle(S - 1);
    wr(8'h98, m0);
    wr(8'h9C, m1);
    idle(S - 1);
    wr(8'h98, 32'd0);
    wr(8'h9C, 32'd0);
    for (int p = 0; p < NP; p++)
      if ((p < 32) ? m0[p] : m1[p - 32]) apply(p, 2'd1);
    chk_pulls("R6 multi-pin pull-down");

    // R7 readback with reserved code (nothing armed)
    wr(8'h94, 32'd3);
    wr(8'h98, 32'hFFFF_FFFF);
    wr(8'h9C, 32'hFFFF_FFFF);
    rd(8'h98, d); chk("R7 word0 readback", d, 32'hFFFF_FFFF);
    rd(8'h9C, d); chk("R7 word1 readback", d, 32'h003F_FFFF);
    rd(8'h94, d); chk("R7 ctrl readback", d, 32'd3);
    rd(8'hA4, d); chk("R7 unmapped A4", d, 0);
    rd(8'h90, d); chk("R7 unmapped 90", d, 0);
    idle(S);
    wr(8'h98, 32'd0);
    wr(8'h9C, 32'd0);
    chk_pulls("R5 reserved code mass clear");

    // R8 automatic sequence
    begin
      int pins [5] = '{0, 31, 32, 53, 17};
      logic [1:0] codes [5] = '{2'd2, 2'd1, 2'd2, 2'd0, 2'd1};
      for (int i = 0; i < 5; i++) begin
        wr(8'hA0, {16'd0, 8'(pins[i]), 6'd0, codes[i]});
        wait_idle(n);
        chk("R8 busy length", n, 2 * S);
        apply(pins[i], codes[i]);
        chk_pulls("R8 auto result");
      end
    end

    // R9 writes ignored while busy
    wr(8'hA0, {16'd0, 8'd10, 6'd0, 2'd1});
    wr(8'h94, 32'd2);
    wr(8'h98, 32'd1 << 11);
    wr(8'hA0, {16'd0, 8'd12, 6'd0, 2'd2});
    rd(8'hA0, d); chk("R8 busy bit during run", d, 32'h8000_0000);
    wait_idle(n);
    chk("R9 busy not retriggered", auto_busy, 0);
    apply(10, 2'd1);
    chk_pulls("R9 only commanded pin changed");
    rd(8'h94, d); chk("R9 ctrl unchanged by busy write", d, 32'd1);
    rd(8'h98, d); chk("R9 word0 unchanged by busy write", d, 0);

    // R10 rejected commands
    wr(8'hA0, {16'd0, 8'd20, 6'd0, 2'd3});
    chk("R10 reserved code rejected", auto_busy, 0);
    wr(8'hA0, {16'd0, 8'd54, 6'd0, 2'd1});
    chk("R10 pin 54 rejected", auto_busy, 0);
    wr(8'hA0, {16'd0, 8'd200, 6'd0, 2'd2});
    chk("R10 pin 200 rejected", auto_busy, 0);
    idle(2 * S + 2);
    chk_pulls("R10 pulls unchanged");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule